// File: doc/BRIEF.md
# Interruptible Serial Control-Port Transfer Engine

This block is the device-side controller for a three-wire host control port. The wires are a serial clock, a mode line and a data line. The engine runs on the system clock and detects rising edges of the serial clock. It assembles bytes MSB first and treats each byte as one of two kinds:

- A byte sent while the mode line is low is an operational address.
- A byte sent while the mode line is high is a data or control byte for the last address.

Three kinds of transfer are handled:

- **Status polling.** The device drives its ready flag onto the data line.
- **Item transfers.** A control byte selects an item and a direction. Each later byte then moves one byte of that item, either into or out of a small register file.
- **Coefficient writes.** Each byte fills one entry of a four-entry bank, which is visible on a parallel output.

A coefficient write may arrive in the middle of an item transfer. When it does, the engine parks the item's position. A continue control byte brings the item back at the next byte. The host then sends a fresh operational address and carries on from that byte.

Top module: `ctlport_engine`

## Requirements
- R1: After the operational address 8'h63, every bit the device drives on `port_dout` during the following mode-high phase equals the ready flag. Ready is 1 when the engine is idle.
- R2: Ready reads 0 for BUSY_CYC system cycles after each completed item byte. A completed coefficient byte never lowers ready, so a status read after a coefficient write returns 1.
- R3: In the mode-high phase after address 8'h40, a control byte with bits [6:2] all zero selects an item. Bit 7 gives the direction (1 = read) and bits [1:0] give the item number. The transfer always starts at item byte 0.
- R4: After address 8'h41, each byte moves the next item byte, MSB first. Writes past ITEM_LEN bytes are dropped. Reads past ITEM_LEN return 8'h00.
- R5: Address 8'h50 resets the coefficient pointer to entry 0. Each coefficient byte is stored at the pointer on its eighth clock edge, and the pointer then advances. After entry NCOEF-1 the pointer wraps to entry 0 with no new address. Entry k appears on `coef_o[8k+7:8k]`.
- R6: Address 8'h50, received while an item transfer is active, saves that item's number, direction and byte position. Control byte 8'h7F restores the saved transfer. The next item byte after an 8'h41 address is the one that follows the last byte moved, for both writes and reads.
- R7: A further 8'h50 address received while a transfer is parked leaves the parked context intact. A coefficient write is never itself parked.
- R8: Control byte 8'h7F received with nothing parked changes no transfer state and sets `err_o`. The next valid item control byte clears `err_o`.
- R9: Data bytes sent while the active item is in read direction do not change the item's stored bytes.
- R10: After reset, `err_o` is 0, all coefficients and item bytes are 8'h00, and `port_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_clk | input | 1 | Serial port clock from the host |
| port_mode | input | 1 | Low: address bytes; high: data/control bytes |
| port_din | input | 1 | Serial data from the host |
| port_dout | output | 1 | Serial data to the host (ready flag or item bits) |
| err_o | output | 1 | Continue requested with no parked transfer |
| coef_o | output | NCOEF*8 | Coefficient bank, entry k at bits 8k+7:8k |

## Verification
The suspend-and-resume path is tested twice. One run interrupts a write and the other interrupts a read, and each interruption falls between two bytes of the item. Reading the whole item back afterwards shows whether the resumed transfer landed on byte n+1, restarted at byte 0 or skipped a byte. The write run sends two coefficient addresses inside one suspension, which separates a parked context that survives from one that is overwritten. Coefficient streams of five bytes, followed by one extra address, show both the wrap and the pointer reset. An overlong item write, a write in read direction and a stray continue each show up as a byte that must be missing or unchanged on readback.

// File: rtl/ctlport_engine.sv
module ctlport_engine #(
  parameter int NITEM    = 4,
  parameter int ITEM_LEN = 6,
  parameter int NCOEF    = 4,
  parameter int BUSY_CYC = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_clk,
  input  logic               port_mode,
  input  logic               port_din,
  output logic               port_dout,
  output logic               err_o,
  output logic [NCOEF*8-1:0] coef_o
);
  localparam int IDW = (NITEM > 1) ? $clog2(NITEM) : 1;
  localparam int IXW = $clog2(ITEM_LEN + 1);
  localparam int CPW = (NCOEF > 1) ? $clog2(NCOEF) : 1;
  localparam int BW  = $clog2(BUSY_CYC + 1);
  localparam logic [7:0] ADDR_STAT = 8'h63;
  localparam logic [7:0] ADDR_CTRL = 8'h40;
  localparam logic [7:0] ADDR_DATA = 8'h41;
  localparam logic [7:0] ADDR_COEF = 8'h50;
  localparam logic [7:0] CTRL_CONT = 8'h7F;

  typedef enum logic [2:0] {OP_NONE, OP_STAT, OP_CTRL, OP_DATA, OP_COEF} op_t;

  logic           pclk_q, mode_q;
  logic [2:0]     bitcnt;
  logic [6:0]     rx;
  op_t            op;
  logic           act_v, act_rd, sus_v, sus_rd;
  logic [IDW-1:0] act_id, sus_id;
  logic [IXW-1:0] act_idx, sus_idx;
  logic [CPW-1:0] cptr;
  logic [BW-1:0]  busy;
  logic [7:0]     coef [NCOEF];
  logic [7:0]     mem  [NITEM][ITEM_LEN];

  wire       rise      = port_clk & ~pclk_q;
  wire       byte_done = rise && (bitcnt == 3'd7) && (port_mode == mode_q);
  wire [7:0] rbyte     = {rx, port_din};
  wire       addr_done = byte_done & ~port_mode;
  wire       data_done = byte_done & port_mode;
  wire       rdy       = (busy == '0);
  wire       in_len    = act_idx < IXW'(ITEM_LEN);
  wire [7:0] rd_byte   = in_len ? mem[act_id][act_idx] : 8'h00;

  assign port_dout = port_mode && ((op == OP_STAT && rdy) ||
                     (op == OP_DATA && act_v && act_rd && rd_byte[3'd7 - bitcnt]));

  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    assign coef_o[8*k +: 8] = coef[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q <= 1'b0;
      mode_q <= 1'b0;
      bitcnt <= '0;
      rx     <= '0;
      op     <= OP_NONE;
    end else begin
      pclk_q <= port_clk;
      mode_q <= port_mode;
      if (port_mode != mode_q) bitcnt <= '0;
      else if (rise) bitcnt <= bitcnt + 3'd1;
      if (rise) rx <= {rx[5:0], port_din};
      if (addr_done) begin
        case (rbyte)
          ADDR_STAT: op <= OP_STAT;
          ADDR_CTRL: op <= OP_CTRL;
          ADDR_DATA: op <= OP_DATA;
          ADDR_COEF: op <= OP_COEF;
          default:   op <= OP_NONE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_v <= 1'b0; act_rd <= 1'b0; act_id <= '0; act_idx <= '0;
      sus_v <= 1'b0; sus_rd <= 1'b0; sus_id <= '0; sus_idx <= '0;
      err_o <= 1'b0;
      cptr  <= '0;
      busy  <= '0;
      for (int k = 0; k < NCOEF; k++) coef[k] <= 8'h00;
      for (int i = 0; i < NITEM; i++)
        for (int j = 0; j < ITEM_LEN; j++) mem[i][j] <= 8'h00;
    end else begin
      if (data_done && op == OP_DATA && act_v) busy <= BW'(BUSY_CYC);
      else if (busy != '0) busy <= busy - 1'b1;

      if (addr_done && rbyte == ADDR_COEF) begin
        cptr <= '0;
        if (act_v) begin
          sus_v <= 1'b1; sus_rd <= act_rd; sus_id <= act_id; sus_idx <= act_idx;
          act_v <= 1'b0;
        end
      end

      if (data_done) begin
        case (op)
          OP_CTRL: begin
            if (rbyte == CTRL_CONT) begin
              if (sus_v) begin
                act_v <= 1'b1; act_rd <= sus_rd; act_id <= sus_id; act_idx <= sus_idx;
                sus_v <= 1'b0;
              end else begin
                err_o <= 1'b1;
              end
            end else if (rbyte[6:IDW] == '0) begin
              act_v <= 1'b1; act_rd <= rbyte[7]; act_id <= rbyte[IDW-1:0]; act_idx <= '0;
              sus_v <= 1'b0;
              err_o <= 1'b0;
            end else begin
              act_v <= 1'b0;
            end
          end
          OP_DATA: begin
            if (act_v && in_len) begin
              if (!act_rd) mem[act_id][act_idx] <= rbyte;
              act_idx <= act_idx + 1'b1;
            end
          end
          OP_COEF: begin
            coef[cptr] <= rbyte;
            cptr <= (cptr == CPW'(NCOEF - 1)) ? '0 : cptr + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  p_coef_ptr_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && rbyte == ADDR_COEF |=> cptr == '0);
  p_coef_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_done && op == OP_COEF |=>
      cptr == (($past(cptr) == CPW'(NCOEF - 1)) ? '0 : $past(cptr) + 1'b1));
  p_coef_no_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    data_done && op == OP_COEF && rdy |=> rdy);
  p_suspend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && rbyte == ADDR_COEF && act_v |=>
      sus_v && !act_v && sus_idx == $past(act_idx) && sus_id == $past(act_id));
  p_keep_ctx_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_done && rbyte == ADDR_COEF && !act_v && sus_v |=>
      sus_v && $stable(sus_idx) && $stable(sus_id) && $stable(sus_rd));
  p_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_done && op == OP_CTRL && rbyte == CTRL_CONT && sus_v |=>
      act_v && act_idx == $past(sus_idx) && !sus_v);
  p_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_done && op == OP_CTRL && rbyte == CTRL_CONT && !sus_v |=>
      err_o && $stable(act_idx) && $stable(act_v));
  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act_idx <= IXW'(ITEM_LEN));
endmodule

// File: tb/ctlport_engine_tb_top.sv
module ctlport_engine_tb_top;
  localparam int NCOEF = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_clk = 1'b0, port_mode = 1'b0, port_din = 1'b0;
  logic port_dout, err_o;
  logic [NCOEF*8-1:0] coef_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$], act_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  ctlport_engine dut_i (
    .clk(clk), .rst_n(rst_n), .port_clk(port_clk), .port_mode(port_mode),
    .port_din(port_din), .port_dout(port_dout), .err_o(err_o), .coef_o(coef_o));

  task automatic expect_val(input string tag, input logic [31:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic observe(input logic [31:0] a);
    act_q.push_back(a);
  endtask

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    expect_val(tag, e);
    observe(a);
  endtask

  initial forever begin
    @(negedge clk);
    while (act_q.size() > 0 && exp_q.size() > 0) begin
      logic [31:0] a, e;
      string t;
      a = act_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", t, a, e);
      end
    end
  end

  task automatic set_mode(input logic m);
    if (port_mode != m) begin
      @(negedge clk);
      port_mode = m;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    port_din = b;
    repeat (3) @(negedge clk);
    port_clk = 1'b1;
    repeat (4) @(negedge clk);
    port_clk = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    @(negedge clk);
    port_din = 1'b0;
    repeat (3) @(negedge clk);
    b = port_dout;
    port_clk = 1'b1;
    repeat (4) @(negedge clk);
    port_clk = 1'b0;
  endtask

  task automatic send_byte(input logic m, input logic [7:0] b);
    set_mode(m);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    set_mode(1'b1);
    for (int i = 7; i >= 0; i--) recv_bit(b[i]);
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] e);
    logic [7:0] b;
    expect_val(tag, {24'd0, e});
    recv_byte(b);
    observe({24'd0, b});
  endtask

  task automatic ctrl(input logic [7:0] c);
    send_byte(1'b0, 8'h40);
    send_byte(1'b1, c);
  endtask

  initial begin
    logic v;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    check("R10 err after reset", {31'd0, err_o}, 0);
    check("R10 coef after reset", coef_o, 0);
    check("R10 dout after reset", {31'd0, port_dout}, 0);

    send_byte(1'b0, 8'h63);
    rd_expect("R1 idle status byte", 8'hFF);

    ctrl(8'h00);
    send_byte(1'b0, 8'h41);
    send_byte(1'b1, 8'h11);
    send_byte(1'b0, 8'h63);
    set_mode(1'b1);
    recv_bit(v);
    check("R2 ready low after item byte", {31'd0, v}, 0);
    n = 0;
    while (v == 1'b0 && n < 40) begin recv_bit(v); n++; end
    check("R2 ready returns high", {31'd0, v}, 1);

    ctrl(8'h01);
    send_byte(1'b0, 8'h41);
    for (int i = 0; i < 7; i++) send_byte(1'b1, 8'hA1 + 8'(i));
    ctrl(8'h81);
    check("R3 err clear on valid ctrl", {31'd0, err_o}, 0);
    send_byte(1'b0, 8'h41);
    for (int i = 0; i < 6; i++) rd_expect("R4 item1 readback", 8'hA1 + 8'(i));
    rd_expect("R4 read past length", 8'h00);
    ctrl(8'h80);
    send_byte(1'b0, 8'h41);
    rd_expect("R3 item0 byte0", 8'h11);

    send_byte(1'b0, 8'h50);
    for (int i = 0; i < 5; i++) send_byte(1'b1, 8'hC0 + 8'(i));
    check("R5 coef wrap", coef_o, 32'hC3C2C1C4);
    send_byte(1'b0, 8'h50);
    send_byte(1'b1, 8'hD0);
    check("R5 pointer reset", coef_o, 32'hC3C2C1D0);
    send_byte(1'b0, 8'h63);
    set_mode(1'b1);
    recv_bit(v);
    check("R2 ready high after coef write", {31'd0, v}, 1);

    ctrl(8'h02);
    send_byte(1'b0, 8'h41);
    send_byte(1'b1, 8'hB0);
    send_byte(1'b1, 8'hB1);
    send_byte(1'b0, 8'h50);
    send_byte(1'b1, 8'hE0);
    send_byte(1'b0, 8'h50);
    send_byte(1'b1, 8'hE1);
    ctrl(8'h7F);
    check("R6 no err on valid continue", {31'd0, err_o}, 0);
    send_byte(1'b0, 8'h41);
    for (int i = 2; i < 6; i++) send_byte(1'b1, 8'hB0 + 8'(i));
    check("R7 coef entry0 after two coef addresses", {24'd0, coef_o[7:0]}, 32'hE1);
    ctrl(8'h82);
    send_byte(1'b0, 8'h41);
    for (int i = 0; i < 6; i++) rd_expect("R6 R7 resumed write", 8'hB0 + 8'(i));

    ctrl(8'h81);
    send_byte(1'b0, 8'h41);
    rd_expect("R6 read before interrupt", 8'hA1);
    rd_expect("R6 read before interrupt", 8'hA2);
    send_byte(1'b0, 8'h50);
    send_byte(1'b1, 8'hE2);
    ctrl(8'h7F);
    send_byte(1'b0, 8'h41);
    rd_expect("R6 resumed read", 8'hA3);

    ctrl(8'h7F);
    check("R8 err on stray continue", {31'd0, err_o}, 1);
    send_byte(1'b0, 8'h41);
    rd_expect("R8 transfer state unchanged", 8'hA4);
    ctrl(8'h81);
    check("R8 err cleared", {31'd0, err_o}, 0);
    send_byte(1'b0, 8'h41);
    rd_expect("R3 restart at byte0", 8'hA1);

    ctrl(8'h83);
    send_byte(1'b0, 8'h41);
    send_byte(1'b1, 8'h5A);
    ctrl(8'h83);
    send_byte(1'b0, 8'h41);
    rd_expect("R9 read-direction write ignored", 8'h00);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule